// File: doc/BRIEF.md
# Two-wire register-file slave with pointer auto-increment

This block is a target on a two-wire serial bus (SCL clock, SDA data, both open-drain). It gives a bus master access to a 32-entry, 8-bit register file that sits outside the block, through one 5-bit register pointer. The block oversamples both bus lines with the system clock and detects start, stop and repeated-start conditions. It acknowledges its own 7-bit address, which is fixed by a parameter, and then either stores incoming bytes or returns register contents.

The pointer keeps its value from one transaction to the next. In a write transaction, the first byte after the address loads the pointer, and every byte after that is stored at the pointer. Every byte transferred in either direction moves the pointer on by one, and it wraps from 31 back to 0. A read transaction that starts directly with the read address returns the register after the last one accessed. A random read is a write transaction that carries only the pointer byte, followed by a repeated start and a read. The block drives SDA only by pulling it low (`sda_oe`), and only while SCL is low.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, `sda_oe` and `reg_we` are low and the pointer is 0, so a read transaction issued straight after reset returns register 0.
- R2: The block pulls SDA low during the acknowledge slot of an address byte whose upper seven bits equal `SLAVE_ADDR`. This holds with the R/W bit (bit 0, 1 = read) at 0 and at 1.
- R3: After an address byte that does not match, the block does not drive SDA and does not write the register file until the next start condition. The pointer is left unchanged.
- R4: In a write transaction, the first data byte loads the pointer (its low 5 bits) and is not stored. Each byte after it is written to the register at the pointer with a one-cycle `reg_we` pulse and is acknowledged.
- R5: The pointer advances by one after each stored byte and after each byte fetched for transmission, and it wraps from 5'h1F to 5'h00 in both directions.
- R6: A read transaction with no preceding pointer byte returns the register whose index is one more than the last register accessed by a read or a write.
- R7: A random read (pointer byte, repeated start, read address) returns as its first byte the register that was just addressed.
- R8: An acknowledge (SDA low) from the master after a read byte makes the block send the next sequential register. A not-acknowledge leaves SDA released, and a following stop ends the transaction.
- R9: Read data is sent most significant bit first, and `sda_oe` changes only while SCL is low.
- R10: A stop condition in the middle of a byte aborts it: no write is performed, the pointer does not advance and SDA is released. A start condition in the middle of a byte restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_raddr | output | 5 | Register-file read address (the pointer) |
| reg_rdata | input | 8 | Register-file read data, combinational from `reg_raddr` |
| reg_we | output | 1 | Register-file write strobe, one cycle |
| reg_waddr | output | 5 | Register-file write address |
| reg_wdata | output | 8 | Register-file write data |

## Verification
Some properties hold on every cycle and are checked by the assertions. `sda_oe` only toggles with SCL low, except when a start or stop forces a release. A stop always leaves the block idle with SDA released, and the idle state never drives SDA. Each write strobe lasts one cycle and falls inside an acknowledge the block itself drives. Every pointer step is exactly +1 modulo 32. Other behaviour depends on whole transactions, and only the bench scenarios can show it. These are: the pointer carrying over between transactions, the current-read and random-read results, wraparound of both writes and reads, MSB-first data order, silence toward a foreign address, and aborts by mid-byte stop or start.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_RD_NEXT
  } bus_state_t;

  // Upper seven bits of an address frame compared with the own address.
  function automatic logic addr_match(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

endpackage

// File: rtl/i2c_rf_sampler.sv
module i2c_rf_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high frame a transaction.
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h48,
  parameter int         AW         = 5,
  parameter int         DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ptr_inc,
  output logic          bus_idle
);

  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  bus_state_t      state;
  logic [BCW-1:0]  bitcnt;
  logic [DW-1:0]   rx_sh;
  logic [DW-1:0]   tx_sh;
  logic            ack_on;
  logic            rw_bit;
  logic            first_byte;

  logic            framing;
  logic [DW-1:0]   rx_next;
  logic            byte_in_done;
  logic            tx_load;
  logic            ptr_load;
  logic            wr_commit;

  assign framing      = start_evt | stop_evt;
  assign rx_next      = {rx_sh[DW-2:0], sda_s};
  assign byte_in_done = ~framing & scl_rise & (bitcnt == LAST_BIT) &
                        ((state == ST_ADDR) | (state == ST_WR_BYTE));
  assign tx_load      = ~framing & scl_fall &
                        (((state == ST_ADDR_ACK) & ack_on & rw_bit) | (state == ST_RD_NEXT));
  assign ptr_load     = ~framing & scl_fall & (state == ST_WR_ACK) & ~ack_on & first_byte;
  assign wr_commit    = ~framing & scl_fall & (state == ST_WR_ACK) & ~ack_on & ~first_byte;
  assign ptr_inc      = tx_load | wr_commit;
  assign bus_idle     = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      ack_on     <= 1'b0;
      rw_bit     <= 1'b0;
      first_byte <= 1'b0;
      ptr        <= '0;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (tx_load) begin
        tx_sh  <= rd_data;
        sda_oe <= ~rd_data[DW-1];
        ptr    <= ptr_step(ptr);
        bitcnt <= '0;
        ack_on <= 1'b0;
        state  <= ST_RD_BYTE;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state      <= ST_ADDR;
        sda_oe     <= 1'b0;
        bitcnt     <= '0;
        first_byte <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise) begin
            rx_sh  <= rx_next;
            bitcnt <= bitcnt + BCW'(1);
            if (byte_in_done) begin
              if (addr_match(rx_next, SLAVE_ADDR)) begin
                state  <= ST_ADDR_ACK;
                rw_bit <= sda_s;
                ack_on <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR_BYTE;
            end
          end
          ST_WR_BYTE: if (scl_rise) begin
            rx_sh  <= rx_next;
            bitcnt <= bitcnt + BCW'(1);
            if (byte_in_done) begin
              state  <= ST_WR_ACK;
              ack_on <= 1'b0;
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
              if (ptr_load) begin
                ptr        <= rx_sh[AW-1:0];
                first_byte <= 1'b0;
              end
              if (wr_commit) begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= rx_sh;
                ptr     <= ptr_step(ptr);
              end
            end else begin
              ack_on <= 1'b0;
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RD_ACK;
            end else begin
              bitcnt <= bitcnt + BCW'(1);
              tx_sh  <= {tx_sh[DW-2:0], 1'b0};
              sda_oe <= ~tx_sh[DW-2];
            end
          end
          ST_RD_ACK: if (scl_rise) begin
            state <= sda_s ? ST_IDLE : ST_RD_NEXT;
          end
          ST_RD_NEXT: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h48,
  parameter int         AW          = 5,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_raddr,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [DW-1:0] reg_wdata
);

  logic scl_s;
  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic start_evt;
  logic stop_evt;
  logic ptr_inc;
  logic bus_idle;

  i2c_rf_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_rf_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (reg_rdata),
    .ptr       (reg_raddr),
    .sda_oe    (sda_oe),
    .wr_en     (reg_we),
    .wr_addr   (reg_waddr),
    .wr_data   (reg_wdata),
    .ptr_inc   (ptr_inc),
    .bus_idle  (bus_idle)
  );

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          reg_we,
  input logic          ptr_inc,
  input logic          bus_idle,
  input logic [AW-1:0] reg_raddr
);

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_evt | stop_evt) |-> !scl_s);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && bus_idle));

  p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && !bus_idle));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_we_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_oe);

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc |=> (reg_raddr == $past(reg_raddr) + AW'(1)));

endmodule

bind i2c_regfile_slave i2c_rf_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .reg_we    (reg_we),
  .ptr_inc   (ptr_inc),
  .bus_idle  (bus_idle),
  .reg_raddr (reg_raddr)
);

// File: tb/i2c_regfile_slave_bench.sv
module i2c_regfile_slave_bench;
  localparam logic [6:0] SADDR = 7'h48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [4:0] reg_raddr, reg_waddr;
  logic [7:0] reg_rdata, reg_wdata;
  logic reg_we;

  logic [7:0] mem [32];
  logic [7:0] exp_mem [32];
  logic [4:0] ptr_m;

  typedef struct { logic [4:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t   wq[$];
  logic [7:0] rq[$];

  int  n_checks = 0;
  int  n_fail   = 0;
  int  n_glitch = 0;
  int  n_loud   = 0;
  bit  quiet_watch = 1'b0;
  logic oe_prev = 1'b0;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_raddr];

  i2c_regfile_slave #(.SLAVE_ADDR(SADDR)) u_i2c_regfile_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: register-file writes against the scoreboard queue, SDA timing.
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R3/R4 unexpected write", {19'd0, reg_waddr, reg_wdata}, 32'd0);
        end else begin
          wr_item_t it;
          it = wq.pop_front();
          chk(reg_waddr == it.a && reg_wdata == it.d, "R4 write addr/data",
              {19'd0, reg_waddr, reg_wdata}, {19'd0, it.a, it.d});
        end
        mem[reg_waddr] = reg_wdata;
      end
      if (sda_oe != oe_prev && scl_m) n_glitch++;
      if (quiet_watch && sda_oe) n_loud++;
      oe_prev = sda_oe;
    end
  end

  task automatic q();
    repeat (10) @(negedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    b = sda_line; q();
    scl_m = 1'b0; q();
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic rd_byte(input bit give_ack, input string tag);
    logic [7:0] got;
    logic [7:0] exp;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      got[i] = b;
    end
    send_bit(give_ack ? 1'b0 : 1'b1);
    exp = rq.pop_front();
    chk(got == exp, tag, {24'd0, got}, {24'd0, exp});
  endtask

  // Driver: pointer byte then data bytes, expected writes pushed first.
  task automatic do_write(input logic [4:0] start_reg, input logic [7:0] data[$], input string tag);
    bit ack;
    bus_start();
    wr_byte({SADDR, 1'b0}, ack);
    chk(ack, "R2 write address ack", {31'd0, ack}, 32'd1);
    wr_byte({3'd0, start_reg}, ack);
    chk(ack, "R4 pointer byte ack", {31'd0, ack}, 32'd1);
    ptr_m = start_reg;
    foreach (data[k]) begin
      wq.push_back('{ptr_m, data[k]});
      exp_mem[ptr_m] = data[k];
      ptr_m = ptr_m + 5'd1;
      wr_byte(data[k], ack);
      chk(ack, tag, {31'd0, ack}, 32'd1);
    end
    bus_stop();
  endtask

  task automatic do_read(input int n, input bit random, input logic [4:0] reg_sel, input string tag);
    bit ack;
    if (random) begin
      bus_start();
      wr_byte({SADDR, 1'b0}, ack);
      wr_byte({3'd0, reg_sel}, ack);
      ptr_m = reg_sel;
    end
    bus_start();
    wr_byte({SADDR, 1'b1}, ack);
    chk(ack, "R2 read address ack", {31'd0, ack}, 32'd1);
    for (int k = 0; k < n; k++) begin
      rq.push_back(exp_mem[ptr_m]);
      ptr_m = ptr_m + 5'd1;
      rd_byte(k < n - 1, tag);
    end
    chk(sda_oe == 1'b0, "R8 SDA released after NACK", {31'd0, sda_oe}, 32'd0);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i]     = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    ptr_m = 5'd0;
    repeat (5) @(negedge clk);
    #1;
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    chk(reg_we == 1'b0, "R1 reg_we in reset", {31'd0, reg_we}, 32'd0);
    rst_n = 1'b1;
    q();

    do_read(1, 1'b0, 5'd0, "R1 first read returns register 0");
    do_write(5'd3, '{8'hA1, 8'hB2, 8'hC3}, "R4 data byte ack");
    do_read(2, 1'b0, 5'd0, "R6 R8 current read sequential");
    do_read(1, 1'b1, 5'h10, "R7 random read");
    do_write(5'h1E, '{8'h11, 8'h22, 8'h33}, "R5 write wrap ack");
    do_read(1, 1'b0, 5'd0, "R5 current read after write wrap");
    do_read(3, 1'b1, 5'h1F, "R5 R9 read wrap MSB first");

    // R3: foreign address is ignored until the next start.
    begin
      bit ack;
      bus_start();
      quiet_watch = 1'b1;
      wr_byte({7'h2A, 1'b0}, ack);
      chk(!ack, "R3 foreign address not acked", {31'd0, ack}, 32'd0);
      wr_byte(8'h00, ack);
      chk(!ack, "R3 byte after foreign address", {31'd0, ack}, 32'd0);
      wr_byte(8'h77, ack);
      chk(!ack, "R3 second byte ignored", {31'd0, ack}, 32'd0);
      quiet_watch = 1'b0;
      bus_stop();
      chk(n_loud == 0, "R3 SDA never driven", n_loud, 32'd0);
    end
    do_read(1, 1'b0, 5'd0, "R3 pointer unchanged");

    // R10: stop in the middle of a data byte.
    begin
      bit ack;
      bus_start();
      wr_byte({SADDR, 1'b0}, ack);
      wr_byte(8'h05, ack);
      ptr_m = 5'd5;
      for (int i = 7; i >= 4; i--) send_bit(1'b1);
      bus_stop();
      chk(sda_oe == 1'b0, "R10 SDA released after stop", {31'd0, sda_oe}, 32'd0);
    end
    do_read(1, 1'b0, 5'd0, "R10 no write, no step after stop");

    // R10: repeated start in the middle of a data byte.
    begin
      bit ack;
      bus_start();
      wr_byte({SADDR, 1'b0}, ack);
      wr_byte(8'h09, ack);
      ptr_m = 5'd9;
      for (int i = 0; i < 3; i++) send_bit(1'b0);
    end
    do_read(2, 1'b0, 5'd0, "R10 restart after aborted byte");

    chk(wq.size() == 0, "R4 every expected write seen", wq.size(), 32'd0);
    chk(n_glitch == 0, "R9 SDA changed only with SCL low", n_glitch, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule